// File: doc/BRIEF.md
# Reset Strap Capture and Pad Role Switching

This block reads a group of shared configuration pads once, when the active-low global reset is released. From then on it hands each pad over to its run-time role. While reset is held, every pad is left as a pure input so that board resistors can set its level. The release of reset is brought into the core clock domain through a synchroniser. One strobe cycle then loads all strap levels into holding flops. The captured bits stay fixed until reset is asserted again.

After the capture, each pad takes one of three roles:
- The interface-select pad and the power-switching pad are driven low.
- The charge-mode pad can report the upstream suspend state. It does so only when its enable input is set.
- The gang pad can report whether the upstream link is high-speed. It does so only when its enable input is set.

The captured bits feed the rest of the hub as configuration. In serial-slave mode, two of the straps also supply a two-bit slave address fragment.

Top module: `strap_capture`

## Requirements
- R1: While `rst_n` is low, every `cfg_*` output, `smb_addr_o` and every `pad_*` output (output enables and values) is 0, and the pads are never driven.
- R2: After `rst_n` rises, the straps are loaded on the third rising clock edge. The pad levels present at that edge are the ones captured, and levels held before that edge are not.
- R3: Once captured, the configuration outputs do not change when the strap inputs change. They hold until `rst_n` is asserted again.
- R4: `cfg_i2c_o` equals the captured interface-select strap. A value of 1 selects EEPROM master mode and 0 selects serial-slave mode.
- R5: `smb_addr_o[0]` is the captured power-switching strap and `smb_addr_o[1]` is the captured gang strap when `cfg_i2c_o` is 0. When `cfg_i2c_o` is 1, `smb_addr_o` is 2'b00.
- R6: From the capture edge onward, the interface-select and power-switching pads are driven low (`oe`=1, value 0). Before that edge they are not driven.
- R7: `cfg_auto_n_o` is the captured charge-mode strap, which is active low. After capture, the charge-mode pad drives `hs_susp_i` (1 = suspended) when `susp_out_en_i` is 1.
- R8: After capture, the gang pad drives `hs_conn_i` (1 = high-speed link) when `conn_out_en_i` is 1.
- R9: `cfg_bat_o[i]` is the captured charge-enable strap of port i, where 1 means charging is supported.
- R10: `cfg_nopwrsw_o`, `cfg_ganged_o` and `cfg_pol_hi_o` are the captured power-switching, gang and polarity straps.
- R11: When a status enable is 0, the matching pad has output enable 0 and output value 0.
- R12: Asserting `rst_n` returns all outputs to the R1 state at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Global reset, active low, asynchronous assertion |
| strap_mode_i | input | 1 | Interface-select pad input |
| strap_fpm_i | input | 1 | Power-switching pad input |
| strap_gang_i | input | 1 | Gang pad input |
| strap_auto_i | input | 1 | Charge-mode pad input (active low) |
| strap_pol_i | input | 1 | Power-control polarity pad input |
| strap_bat_i | input | NPORT | Per-port charge-enable pad inputs |
| hs_conn_i | input | 1 | Upstream high-speed link status from the core |
| hs_susp_i | input | 1 | Upstream suspend status from the core |
| conn_out_en_i | input | 1 | Enables link status output on the gang pad |
| susp_out_en_i | input | 1 | Enables suspend status output on the charge-mode pad |
| cfg_i2c_o | output | 1 | Captured interface select |
| cfg_nopwrsw_o | output | 1 | Captured power-switching strap |
| cfg_ganged_o | output | 1 | Captured gang strap |
| cfg_auto_n_o | output | 1 | Captured charge-mode strap |
| cfg_pol_hi_o | output | 1 | Captured polarity strap |
| cfg_bat_o | output | NPORT | Captured per-port charge enables |
| smb_addr_o | output | 2 | Slave address fragment |
| pad_mode_oe_o | output | 1 | Interface-select pad output enable |
| pad_mode_o | output | 1 | Interface-select pad output value |
| pad_fpm_oe_o | output | 1 | Power-switching pad output enable |
| pad_fpm_o | output | 1 | Power-switching pad output value |
| pad_auto_oe_o | output | 1 | Charge-mode pad output enable |
| pad_auto_o | output | 1 | Charge-mode pad output value |
| pad_gang_oe_o | output | 1 | Gang pad output enable |
| pad_gang_o | output | 1 | Gang pad output value |

## Verification
Two things happen at the same clock edge: the straps are captured, and the pads are turned into outputs. A pad must not be driven one cycle early, or it would corrupt its own strap. The bench first holds the inverse of each strap pattern through the early part of release. It then switches to the true pattern one cycle before capture and inverts it again right after capture. The sweep covers every strap pattern. The bench requires that the captured bits equal the pattern present at the capture edge, and that the output enables are still low one cycle before that edge and high right after it.

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int NPORT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_mode_i,
  input  logic             strap_fpm_i,
  input  logic             strap_gang_i,
  input  logic             strap_auto_i,
  input  logic             strap_pol_i,
  input  logic [NPORT-1:0] strap_bat_i,
  input  logic             hs_conn_i,
  input  logic             hs_susp_i,
  input  logic             conn_out_en_i,
  input  logic             susp_out_en_i,
  output logic             cfg_i2c_o,
  output logic             cfg_nopwrsw_o,
  output logic             cfg_ganged_o,
  output logic             cfg_auto_n_o,
  output logic             cfg_pol_hi_o,
  output logic [NPORT-1:0] cfg_bat_o,
  output logic [1:0]       smb_addr_o,
  output logic             pad_mode_oe_o,
  output logic             pad_mode_o,
  output logic             pad_fpm_oe_o,
  output logic             pad_fpm_o,
  output logic             pad_auto_oe_o,
  output logic             pad_auto_o,
  output logic             pad_gang_oe_o,
  output logic             pad_gang_o
);

  localparam int CFGW = 5 + NPORT;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   live_q;
  logic [CFGW-1:0]        cfg_q;
  logic [CFGW-1:0]        strap_vec;
  logic                   cap;

  assign strap_vec = {strap_bat_i, strap_pol_i, strap_auto_i,
                      strap_gang_i, strap_fpm_i, strap_mode_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign cap = sync_q[SYNC_STAGES-1] & ~live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      cfg_q  <= '0;
    end else if (cap) begin
      live_q <= 1'b1;
      cfg_q  <= strap_vec;
    end
  end

  assign cfg_i2c_o     = cfg_q[0];
  assign cfg_nopwrsw_o = cfg_q[1];
  assign cfg_ganged_o  = cfg_q[2];
  assign cfg_auto_n_o  = cfg_q[3];
  assign cfg_pol_hi_o  = cfg_q[4];
  assign cfg_bat_o     = cfg_q[CFGW-1:5];

  assign smb_addr_o = cfg_q[0] ? 2'b00 : {cfg_q[2], cfg_q[1]};

  assign pad_mode_oe_o = live_q;
  assign pad_mode_o    = 1'b0;
  assign pad_fpm_oe_o  = live_q;
  assign pad_fpm_o     = 1'b0;
  assign pad_auto_oe_o = live_q & susp_out_en_i;
  assign pad_auto_o    = pad_auto_oe_o & hs_susp_i;
  assign pad_gang_oe_o = live_q & conn_out_en_i;
  assign pad_gang_o    = pad_gang_oe_o & hs_conn_i;

  p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (live_q && cfg_q == $past(strap_vec)));

  p_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> $stable(cfg_q));

  p_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !live_q |-> (cfg_q == '0 && !pad_mode_oe_o && !pad_fpm_oe_o &&
                 !pad_auto_oe_o && !pad_gang_oe_o));

  p_drive_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (pad_mode_oe_o && !pad_mode_o && pad_fpm_oe_o && !pad_fpm_o));

  p_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i2c_o |-> (smb_addr_o == 2'b00));

  p_status_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!susp_out_en_i |-> (!pad_auto_oe_o && !pad_auto_o)) and
    (!conn_out_en_i |-> (!pad_gang_oe_o && !pad_gang_o)));

endmodule

// File: tb/strap_capture_bench.sv
module strap_capture_bench;
  localparam int NPORT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_mode = 0, s_fpm = 0, s_gang = 0, s_auto = 0, s_pol = 0;
  logic [NPORT-1:0] s_bat = '0;
  logic hs_conn = 0, hs_susp = 0, conn_en = 0, susp_en = 0;

  logic c_i2c, c_nopw, c_gang, c_auton, c_pol;
  logic [NPORT-1:0] c_bat;
  logic [1:0] saddr;
  logic m_oe, m_o, f_oe, f_o, a_oe, a_o, g_oe, g_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  strap_capture #(.NPORT(NPORT), .SYNC_STAGES(2)) u_strap_capture (
    .clk(clk), .rst_n(rst_n),
    .strap_mode_i(s_mode), .strap_fpm_i(s_fpm), .strap_gang_i(s_gang),
    .strap_auto_i(s_auto), .strap_pol_i(s_pol), .strap_bat_i(s_bat),
    .hs_conn_i(hs_conn), .hs_susp_i(hs_susp),
    .conn_out_en_i(conn_en), .susp_out_en_i(susp_en),
    .cfg_i2c_o(c_i2c), .cfg_nopwrsw_o(c_nopw), .cfg_ganged_o(c_gang),
    .cfg_auto_n_o(c_auton), .cfg_pol_hi_o(c_pol), .cfg_bat_o(c_bat),
    .smb_addr_o(saddr),
    .pad_mode_oe_o(m_oe), .pad_mode_o(m_o), .pad_fpm_oe_o(f_oe), .pad_fpm_o(f_o),
    .pad_auto_oe_o(a_oe), .pad_auto_o(a_o), .pad_gang_oe_o(g_oe), .pad_gang_o(g_o)
  );

  wire [8:0] cfg_all  = {c_bat, c_pol, c_auton, c_gang, c_nopw, c_i2c};
  wire [7:0] pads_all = {m_oe, m_o, f_oe, f_o, a_oe, a_o, g_oe, g_o};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_straps(input logic [8:0] p);
    s_mode = p[0]; s_fpm = p[1]; s_gang = p[2]; s_auto = p[3]; s_pol = p[4];
    s_bat  = p[8:5];
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " cfg"}, {23'd0, cfg_all}, 32'd0);
    chk({tag, " addr"}, {30'd0, saddr}, 32'd0);
    chk({tag, " pads"}, {24'd0, pads_all}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    for (int p = 0; p < 512; p++) begin
      logic [8:0] pv;
      logic [1:0] ea;
      pv = p[8:0];
      @(negedge clk);
      rst_n = 1'b0;
      set_straps(~pv);
      {conn_en, susp_en, hs_conn, hs_susp} = 4'b1111;
      #1;
      chk_idle("R12 async reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      set_straps(pv);
      @(negedge clk);
      chk("R6 not driven before capture", {30'd0, m_oe, f_oe}, 32'd0);
      chk("R1 cfg before capture", {23'd0, cfg_all}, 32'd0);
      @(negedge clk);
      chk("R2 captured", {23'd0, cfg_all}, {23'd0, pv});
      chk("R4 i2c", {31'd0, c_i2c}, {31'd0, pv[0]});
      chk("R10 nopw gang pol", {29'd0, c_nopw, c_gang, c_pol}, {29'd0, pv[1], pv[2], pv[4]});
      chk("R7 auto_n", {31'd0, c_auton}, {31'd0, pv[3]});
      chk("R9 bat", {28'd0, c_bat}, {28'd0, pv[8:5]});
      ea = pv[0] ? 2'b00 : {pv[2], pv[1]};
      chk("R5 addr", {30'd0, saddr}, {30'd0, ea});
      chk("R6 driven low", {28'd0, m_oe, m_o, f_oe, f_o}, 32'd10);
      set_straps(~pv);
      for (int c = 0; c < 16; c++) begin
        logic [3:0] exp4;
        {conn_en, susp_en, hs_conn, hs_susp} = c[3:0];
        #1;
        exp4 = {c[2], c[2] & c[0], c[3], c[3] & c[1]};
        chk("R7 R8 R11 status pads", {28'd0, a_oe, a_o, g_oe, g_o}, {28'd0, exp4});
      end
      @(negedge clk);
      @(negedge clk);
      chk("R3 held after strap change", {23'd0, cfg_all}, {23'd0, pv});
      chk("R6 still driven", {28'd0, m_oe, m_o, f_oe, f_o}, 32'd10);
    end
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_idle("R12 final reset");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule